// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives a card clock from the reference clock using a programmable divider and an enable bit. Software writes the divider and enable values into holding registers; they do nothing until a clock-update command is written to the command register. That command raises a start bit. The start bit stays set while the block applies the new settings, and clears itself once they are live. Software polls the start bit to learn when the change is complete.

An optional wait flag in the command holds the update back while a data-busy status input is high. Writing a second command while one is still pending is refused and raises a sticky locked-command error. Software clears that error by writing a 1 to it. The card clock changes only at the end of a whole period, so enabling, disabling or re-dividing it never produces a shortened pulse.

Register word addresses: divider 0 (bits 7:0), enable 1 (bit 0), source select 2 (bits 1:0, storage only), command 3, raw interrupt 4, status 5.

Top module: `cclk_gen`

## Requirements
- R1: With divider value N in 1..255 applied and the clock enabled, each high phase and each low phase of `card_clk` lasts exactly N reference cycles, so the period is 2*N. An applied value of 0 behaves as 1.
- R2: Writes to the divider and enable registers leave `card_clk` unchanged until an update completes. Reading these registers returns the value last written.
- R3: Writing the command register with bit 31 (start) and bit 21 (update-only) both set makes bit 31 read 1 for exactly UPD_LAT reference cycles after the write edge, then 0. The settings held at that moment are applied when it clears.
- R4: When the command also has bit 13 (wait-for-data) set, completion waits while `data_busy` is high. Start then clears on the UPD_LAT-th cycle with `data_busy` low. Without bit 13, `data_busy` has no effect on the timing.
- R5: A command write with bit 31 set while start is still 1 sets raw interrupt bit 12 and drives `lock_err_flag` high. The refused write does not change when the pending update completes.
- R6: Writing 1 to raw interrupt bit 12 clears it. Writing 0 leaves it set.
- R7: With enable bit 0 cleared and applied, the clock stops low only after a full low phase. Every high phase seen around the stop has full length, and `card_clk` then stays low.
- R8: Status bit 9 reads the current level of `data_busy`.
- R9: A command with bit 31 set and bit 21 clear completes with the same timing but applies no divider or enable change.
- R10: After reset, `card_clk` is 0, the divider reads 1, enable reads 0, command bit 31 reads 0, and the raw interrupt register and `lock_err_flag` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| data_busy | input | 1 | Data path busy status |
| card_clk | output | 1 | Divided card clock |
| lock_err_flag | output | 1 | Sticky locked-command error |

## Verification
The divider is tried with a table of values: the smallest (1), even and odd values (2, 3, 7), and the out-of-range 0. Measuring both phase lengths separates a correct half-period counter from off-by-one and phase-asymmetry faults. Handshake timing is counted cycle by cycle under four conditions: a plain update, an update that waits while busy, a busy level that is ignored because the wait flag is clear, and an update without the update-only flag. These separate the latency counter, the busy gate and the apply gating. A refused second command, a stop of the clock, and pending writes without an update check that the settings stay isolated and that no runt pulse appears.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
   // register word addresses
   localparam int A_DIV  = 0;
   localparam int A_ENA  = 1;
   localparam int A_SRC  = 2;
   localparam int A_CMD  = 3;
   localparam int A_RINT = 4;
   localparam int A_STAT = 5;
   // bit positions software depends on
   localparam int CMD_START_BIT = 31;
   localparam int CMD_UPD_BIT   = 21;
   localparam int CMD_WAIT_BIT  = 13;
   localparam int RINT_LOCK_BIT = 12;
   localparam int STAT_BUSY_BIT = 9;
endpackage

// File: rtl/cclk_divider.sv
module cclk_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] req_div,
   input  logic             req_en,
   output logic [DIV_W-1:0] run_div_o,
   output logic             card_clk_o
);
   logic [DIV_W-1:0] cnt_q, run_div_q, eff_div;
   logic             run_en_q, clk_q, at_end;

   assign eff_div = (req_div == '0) ? DIV_W'(1) : req_div;
   assign at_end  = (cnt_q == run_div_q - DIV_W'(1));

   // new settings load only at a period boundary (end of low phase) or while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         run_div_q <= DIV_W'(1);
         run_en_q  <= 1'b0;
         clk_q     <= 1'b0;
      end else if (!run_en_q || (at_end && !clk_q)) begin
         cnt_q     <= '0;
         run_div_q <= eff_div;
         run_en_q  <= req_en;
         clk_q     <= req_en;
      end else if (at_end) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign run_div_o  = run_div_q;
   assign card_clk_o = clk_q;
endmodule

// File: rtl/cclk_update_seq.sv
module cclk_update_seq #(
   parameter int DIV_W   = 8,
   parameter int UPD_LAT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_req,
   input  logic             req_upd,
   input  logic             req_wait,
   input  logic             data_busy,
   input  logic [DIV_W-1:0] div_pend,
   input  logic             ena_pend,
   output logic             start_o,
   output logic             upd_o,
   output logic             wait_o,
   output logic             lock_err_o,
   output logic [DIV_W-1:0] act_div,
   output logic             act_en
);
   localparam int CW = (UPD_LAT > 1) ? $clog2(UPD_LAT) : 1;

   logic start_q, upd_q, wait_q, blocked, done, accept;

   assign blocked    = wait_q & data_busy;
   assign accept     = cmd_req & ~start_q;
   assign lock_err_o = cmd_req & start_q;

   generate
      if (UPD_LAT == 1) begin : g_lat1
         assign done = start_q & ~blocked;
      end else begin : g_latn
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (!start_q || blocked) cnt_q <= '0;
            else                        cnt_q <= cnt_q + CW'(1);
         end
         assign done = start_q & ~blocked & (cnt_q == CW'(UPD_LAT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         upd_q   <= 1'b0;
         wait_q  <= 1'b0;
      end else if (accept) begin
         start_q <= 1'b1;
         upd_q   <= req_upd;
         wait_q  <= req_wait;
      end else if (done) begin
         start_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div <= DIV_W'(1);
         act_en  <= 1'b0;
      end else if (done && upd_q) begin
         act_div <= div_pend;
         act_en  <= ena_pend;
      end
   end

   assign start_o = start_q;
   assign upd_o   = upd_q;
   assign wait_o  = wait_q;
endmodule

// File: rtl/cclk_regs.sv
module cclk_regs
   import cclk_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              start,
   input  logic              upd,
   input  logic              wait_f,
   input  logic              data_busy,
   input  logic              lock_err,
   output logic [DIV_W-1:0]  div_q,
   output logic              ena_q,
   output logic              lock_q,
   output logic [DATA_W-1:0] rdata
);
   logic [1:0] src_q;
   logic       unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(1);
         ena_q <= 1'b0;
         src_q <= 2'b00;
      end else if (we) begin
         if (addr == ADDR_W'(A_DIV)) div_q <= wdata[DIV_W-1:0];
         if (addr == ADDR_W'(A_ENA)) ena_q <= wdata[0];
         if (addr == ADDR_W'(A_SRC)) src_q <= wdata[1:0];
      end
   end

   // sticky error: set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (lock_err)
         lock_q <= 1'b1;
      else if (we && addr == ADDR_W'(A_RINT) && wdata[RINT_LOCK_BIT])
         lock_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_DIV):  rdata[DIV_W-1:0] = div_q;
         ADDR_W'(A_ENA):  rdata[0] = ena_q;
         ADDR_W'(A_SRC):  rdata[1:0] = src_q;
         ADDR_W'(A_CMD): begin
            rdata[CMD_START_BIT] = start;
            rdata[CMD_UPD_BIT]   = upd;
            rdata[CMD_WAIT_BIT]  = wait_f;
         end
         ADDR_W'(A_RINT): rdata[RINT_LOCK_BIT] = lock_q;
         ADDR_W'(A_STAT): rdata[STAT_BUSY_BIT] = data_busy;
         default:         rdata = '0;
      endcase
   end
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
   import cclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int UPD_LAT = 4,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              data_busy,
   output logic              card_clk,
   output logic              lock_err_flag
);
   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("DATA_W must hold bit 31 of the command register");
      end
      if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div_w
         $error("DIV_W out of range");
      end
      if (UPD_LAT < 1) begin : g_bad_lat
         $error("UPD_LAT must be at least 1");
      end
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic             cmd_req, start_s, upd_s, wait_s, lock_err_s, ena_pend, act_en;
   logic [DIV_W-1:0] div_pend, act_div, run_div;

   assign cmd_req = reg_we && (reg_addr == ADDR_W'(A_CMD)) && reg_wdata[CMD_START_BIT];

   cclk_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .start(start_s), .upd(upd_s), .wait_f(wait_s), .data_busy(data_busy),
      .lock_err(lock_err_s), .div_q(div_pend), .ena_q(ena_pend),
      .lock_q(lock_err_flag), .rdata(reg_rdata)
   );

   cclk_update_seq #(.DIV_W(DIV_W), .UPD_LAT(UPD_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req),
      .req_upd(reg_wdata[CMD_UPD_BIT]), .req_wait(reg_wdata[CMD_WAIT_BIT]),
      .data_busy(data_busy), .div_pend(div_pend), .ena_pend(ena_pend),
      .start_o(start_s), .upd_o(upd_s), .wait_o(wait_s), .lock_err_o(lock_err_s),
      .act_div(act_div), .act_en(act_en)
   );

   cclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .req_div(act_div), .req_en(act_en),
      .run_div_o(run_div), .card_clk_o(card_clk)
   );
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_req,
   input logic             start,
   input logic             wait_f,
   input logic             data_busy,
   input logic             lock_flag,
   input logic             card_clk,
   input logic [DIV_W-1:0] run_div,
   input logic [DIV_W-1:0] act_div,
   input logic             act_en
);
   logic [DIV_W:0]   hi_cnt;
   logic [DIV_W-1:0] hi_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         hi_div <= '0;
      end else if (card_clk) begin
         hi_cnt <= hi_cnt + 1'b1;
         hi_div <= run_div;
      end else begin
         hi_cnt <= '0;
      end
   end

   p_full_high_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_clk) |-> (hi_cnt == {1'b0, hi_div}));

   p_frozen_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(act_div) && $stable(act_en)));

   p_start_raised_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !start) |=> start);

   p_held_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && wait_f && data_busy) |=> start);

   p_lock_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && start) |=> lock_flag);

   p_stopped_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_en && !card_clk) |=> !card_clk);
endmodule

bind cclk_gen cclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .start(start_s), .wait_f(wait_s),
   .data_busy(data_busy), .lock_flag(lock_err_flag), .card_clk(card_clk),
   .run_div(run_div), .act_div(act_div), .act_en(act_en)
);

// File: tb/tb_cclk_gen.sv
`timescale 1ns/1ps
module tb_cclk_gen;
   import cclk_pkg::*;
   localparam int DIV_W = 8, UPD_LAT = 4, ADDR_W = 3, DATA_W = 32;
   localparam logic [31:0] C_START = 32'h1 << CMD_START_BIT;
   localparam logic [31:0] C_UPD   = 32'h1 << CMD_UPD_BIT;
   localparam logic [31:0] C_WAIT  = 32'h1 << CMD_WAIT_BIT;
   // {divider value, expected half period}
   localparam logic [15:0] VEC [5] = '{16'h0101, 16'h0303, 16'h0202, 16'h0707, 16'h0001};

   logic clk = 0, rst_n = 0, reg_we = 0, data_busy = 0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
   logic card_clk, lock_err_flag;
   int checks = 0, fails = 0;
   bit finished = 0;
   bit mon_on = 0;
   int mon_exp = 0, mon_run = 0;

   always #2.5 clk = ~clk;

   cclk_gen #(.DIV_W(DIV_W), .UPD_LAT(UPD_LAT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_busy(data_busy),
      .card_clk(card_clk), .lock_err_flag(lock_err_flag));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = ADDR_W'(a);
      #1 d = reg_rdata;
   endtask

   // write a command, then count sampled cycles with start still 1
   task automatic cmd_count(input logic [31:0] c, output int n);
      logic [31:0] v;
      wr(A_CMD, c);
      n = 0;
      rd(A_CMD, v);
      while (v[CMD_START_BIT] && n < 1000) begin
         n++;
         @(negedge clk);
         rd(A_CMD, v);
      end
   endtask

   task automatic measure(output int hi, output int lo);
      logic prev;
      int g = 0;
      hi = 0; lo = 0;
      @(negedge clk); prev = card_clk;
      while (!(card_clk && !prev) && g < 2000) begin
         prev = card_clk; @(negedge clk); g++;
      end
      while (card_clk && g < 4000) begin hi++; @(negedge clk); g++; end
      while (!card_clk && g < 6000) begin lo++; @(negedge clk); g++; end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (card_clk) mon_run++;
         else if (mon_run != 0) begin
            chk(mon_run == mon_exp, "R7 high phase length", mon_run, mon_exp);
            mon_run = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n, hi, lo;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      repeat (6) @(negedge clk);
      chk(card_clk == 0, "R10 card_clk", card_clk, 0);
      rd(A_DIV, v);  chk(v == 1, "R10 divider", v, 1);
      rd(A_ENA, v);  chk(v == 0, "R10 enable", v, 0);
      rd(A_CMD, v);  chk(v[CMD_START_BIT] == 0, "R10 start", v[CMD_START_BIT], 0);
      rd(A_RINT, v); chk(v == 0, "R10 raw interrupt", v, 0);
      chk(lock_err_flag == 0, "R10 lock flag", lock_err_flag, 0);

      // R1 / R3 table walk
      wr(A_ENA, 1);
      foreach (VEC[i]) begin
         wr(A_DIV, {24'd0, VEC[i][15:8]});
         cmd_count(C_START | C_UPD, n);
         chk(n == UPD_LAT, "R3 start cycles", n, UPD_LAT);
         measure(hi, lo);
         chk(hi == int'(VEC[i][7:0]), "R1 high phase", hi, VEC[i][7:0]);
         chk(lo == int'(VEC[i][7:0]), "R1 low phase", lo, VEC[i][7:0]);
      end

      // set divider 3
      wr(A_DIV, 3);
      cmd_count(C_START | C_UPD, n);

      // R2 pending write does not reach the clock
      wr(A_DIV, 6);
      rd(A_DIV, v); chk(v == 6, "R2 readback", v, 6);
      measure(hi, lo);
      chk(hi == 3 && lo == 3, "R2 clock unchanged", hi, 3);

      // R9 start without update-only applies nothing
      cmd_count(C_START, n);
      chk(n == UPD_LAT, "R9 start cycles", n, UPD_LAT);
      measure(hi, lo);
      chk(hi == 3, "R9 divider not applied", hi, 3);
      wr(A_DIV, 3);

      // R8 status
      data_busy = 1;
      rd(A_STAT, v); chk(v[STAT_BUSY_BIT] == 1, "R8 busy high", v[STAT_BUSY_BIT], 1);
      // R4 busy ignored without wait flag
      cmd_count(C_START | C_UPD, n);
      chk(n == UPD_LAT, "R4 busy ignored", n, UPD_LAT);
      // R4 wait flag holds while busy
      wr(A_CMD, C_START | C_UPD | C_WAIT);
      n = 0;
      for (int k = 0; k < 10; k++) begin
         rd(A_CMD, v);
         if (v[CMD_START_BIT]) n++;
         @(negedge clk);
      end
      chk(n == 10, "R4 held while busy", n, 10);
      data_busy = 0;
      rd(A_STAT, v); chk(v[STAT_BUSY_BIT] == 0, "R8 busy low", v[STAT_BUSY_BIT], 0);
      n = 0;
      rd(A_CMD, v);
      while (v[CMD_START_BIT] && n < 1000) begin
         n++; @(negedge clk); rd(A_CMD, v);
      end
      chk(n == UPD_LAT, "R4 cycles after busy low", n, UPD_LAT);

      // R5 second command while pending
      @(negedge clk);
      reg_we = 1; reg_addr = ADDR_W'(A_CMD); reg_wdata = C_START | C_UPD;
      @(negedge clk);
      @(negedge clk);
      reg_we = 0;
      n = 0;
      rd(A_CMD, v);
      while (v[CMD_START_BIT] && n < 1000) begin
         n++; @(negedge clk); rd(A_CMD, v);
      end
      chk(n == UPD_LAT - 1, "R5 refused write keeps timing", n, UPD_LAT - 1);
      rd(A_RINT, v);
      chk(v[RINT_LOCK_BIT] == 1, "R5 raw bit 12", v[RINT_LOCK_BIT], 1);
      chk(lock_err_flag == 1, "R5 lock flag", lock_err_flag, 1);
      // R6 write-one-to-clear
      wr(A_RINT, 0);
      rd(A_RINT, v); chk(v[RINT_LOCK_BIT] == 1, "R6 write 0 keeps", v[RINT_LOCK_BIT], 1);
      wr(A_RINT, 32'h1 << RINT_LOCK_BIT);
      rd(A_RINT, v); chk(v[RINT_LOCK_BIT] == 0, "R6 write 1 clears", v[RINT_LOCK_BIT], 0);
      chk(lock_err_flag == 0, "R6 lock flag", lock_err_flag, 0);

      // R7 stop the clock cleanly
      while (card_clk) @(negedge clk);
      mon_exp = 3; mon_run = 0; mon_on = 1;
      wr(A_ENA, 0);
      cmd_count(C_START | C_UPD, n);
      repeat (8) @(negedge clk);
      n = 0;
      for (int k = 0; k < 30; k++) begin
         if (card_clk) n++;
         @(negedge clk);
      end
      mon_on = 0;
      chk(n == 0, "R7 stays low", n, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule